// File: doc/BRIEF.md
# Dual PLL Lock-Up Sequencing Controller

This block supervises two clock multipliers that share one high-frequency oscillator: a system PLL, whose output can become the core clock, and a second PLL reserved for the USB clock domain. The analog loops themselves are not modelled. The block drives an enable line for each loop, a multiplier-select line and a clock-source select line. It times each loop's stabilisation with its own binary counter, which runs on the oscillator clock.

Software reaches the block through a single-cycle register write port and a combinational read port with two registers. A loop starts when its enable bit is written to 1. Software then polls a lock-up flag until the flag clears, and only after that may it move the system clock onto the system PLL. The block lets only one loop be in its settling period at any time. An enable that would break this rule is dropped, and the attempt is recorded in a sticky error bit.

Top module: `pll_lockup_ctrl`

## Requirements
- R1: After reset, both enables, the clock-source select, the multiplier select and the error bit are 0, and both registers read 0.
- R2: When the system PLL enable is accepted at a clock edge, the system loop counts as locking for exactly 2^SYS_LOCK_STAGES edges after that edge. It counts as locked from the edge 2^SYS_LOCK_STAGES edges later onward.
- R3: The same timing applies to the USB PLL, with a length of 2^USB_LOCK_STAGES edges.
- R4: Register 0 holds: bit 0 = clock-source select, bit 1 = lock-up flag (read-only), bit 2 = multiplier select (0 gives x12, 1 gives x16), bit 3 = sticky error. The flag reads 1 while either enabled loop is still locking and 0 otherwise. It reads 1 again on every new start.
- R5: Writing 1 to the select bit takes effect only when the system PLL is enabled and locked. Otherwise the oscillator stays selected. Writing 0 always selects the oscillator.
- R6: Register 1 holds bit 0 = system PLL enable and bit 1 = USB PLL enable. A 0-to-1 enable write is ignored while the other loop is locking. If both bits rise in the same write, only the system PLL starts.
- R7: Each ignored start sets the error bit. The bit stays set until software writes 1 to bit 3 of register 0.
- R8: Clearing an enable stops that loop at once and restarts its count from zero. Clearing the system enable also returns the clock select to the oscillator on the same edge.
- R9: Writes to the multiplier select take effect only while the system PLL is disabled.
- R10: Reading register 1 returns the current enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 1 | Write register index (0 or 1) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read register index |
| rd_data | output | DATA_W | Combinational read data |
| sys_pll_en | output | 1 | Run enable for the system PLL |
| usb_pll_en | output | 1 | Run enable for the USB PLL |
| pll_mul16 | output | 1 | Multiplier select: 1 gives x16, 0 gives x12 |
| clk_sel_pll | output | 1 | System clock source: 1 is the PLL, 0 is the oscillator |

## Verification
Every register, enable, select and error effect of a write appears right after the single edge that captures the write. The lock-up flag falls exactly 2^N edges after the edge that accepted the enable. The bench drives each write for one edge from a falling edge, so it always knows which edge captured the write. It reads results in the middle of the low phase. For each lock period it sweeps the flag cycle by cycle, expecting 1 while the number of edges since the start is below 2^N and 0 from that point on. It runs both timers with small stage counts, so every count of the period is observed.

// File: rtl/pll_lockup_pkg.sv
package pll_lockup_pkg;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_ENA  = 1;

  localparam int unsigned CTRL_SEL_BIT  = 0;
  localparam int unsigned CTRL_FLAG_BIT = 1;
  localparam int unsigned CTRL_MUL_BIT  = 2;
  localparam int unsigned CTRL_ERR_BIT  = 3;

  localparam int unsigned ENA_SYS_BIT = 0;
  localparam int unsigned ENA_USB_BIT = 1;

  localparam int unsigned MIN_DATA_W = 4;

  typedef struct packed {
    logic usb;
    logic sys;
  } pll_pair_t;

endpackage

// File: rtl/lockup_timer.sv
module lockup_timer #(
  parameter int unsigned STAGES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  logic [STAGES-1:0] cnt_q;
  logic              done_q;
  logic              at_top;

  assign at_top = &cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (at_top) done_q <= 1'b1;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/start_guard.sv
module start_guard
  import pll_lockup_pkg::*;
(
  input  pll_pair_t cur_en,
  input  pll_pair_t busy,
  input  pll_pair_t req,
  output pll_pair_t nxt_en,
  output logic      reject
);

  logic sys_up, usb_up, sys_ok, usb_ok;

  always_comb begin
    sys_up = req.sys & ~cur_en.sys;
    usb_up = req.usb & ~cur_en.usb;
    // the system loop has priority when both rise together
    sys_ok = sys_up & ~busy.usb;
    usb_ok = usb_up & ~busy.sys & ~sys_ok;

    nxt_en.sys = cur_en.sys ? req.sys : sys_ok;
    nxt_en.usb = cur_en.usb ? req.usb : usb_ok;

    reject = (sys_up & ~sys_ok) | (usb_up & ~usb_ok);
  end

endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import pll_lockup_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_ena,
  input  logic [DATA_W-1:0] wdata,
  input  pll_pair_t         ena_nxt,
  input  logic              start_reject,
  input  logic              sys_locked,
  output pll_pair_t         ena_q,
  output logic              sel_q,
  output logic              mul_q,
  output logic              err_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (wr_ena) begin
      ena_q <= ena_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (wr_ena && !ena_nxt.sys) begin
      sel_q <= 1'b0;
    end else if (wr_ctrl) begin
      sel_q <= wdata[CTRL_SEL_BIT] & sys_locked;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul_q <= 1'b0;
    end else if (wr_ctrl && !ena_q.sys) begin
      mul_q <= wdata[CTRL_MUL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (wr_ena && start_reject) begin
      err_q <= 1'b1;
    end else if (wr_ctrl && wdata[CTRL_ERR_BIT]) begin
      err_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_lockup_ctrl.sv
module pll_lockup_ctrl
  import pll_lockup_pkg::*;
#(
  parameter int unsigned SYS_LOCK_STAGES = 12,
  parameter int unsigned USB_LOCK_STAGES = 13,
  parameter int unsigned DATA_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_pll_en,
  output logic              usb_pll_en,
  output logic              pll_mul16,
  output logic              clk_sel_pll
);

  localparam int unsigned NUM_PLL = 2;
  localparam int unsigned STAGES_SYS = SYS_LOCK_STAGES;
  localparam int unsigned STAGES_USB = USB_LOCK_STAGES;

  initial begin
    if (DATA_W < MIN_DATA_W) $error("DATA_W too small for register map");
  end

  pll_pair_t ena_q, ena_nxt, busy, req, lock_done;
  logic      sys_lock_done, usb_lock_done;
  logic      wr_ctrl, wr_ena, start_reject;
  logic      sel_q, mul_q, err_q, lock_flag;

  assign wr_ctrl = wr_en && (wr_addr == 1'(REG_CTRL));
  assign wr_ena  = wr_en && (wr_addr == 1'(REG_ENA));

  assign req.sys = wr_data[ENA_SYS_BIT];
  assign req.usb = wr_data[ENA_USB_BIT];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PLL; gi++) begin : g_timer
      if (gi == 0) begin : g_sys
        lockup_timer #(.STAGES(STAGES_SYS)) timer_i (
          .clk  (clk),
          .rst_n(rst_n),
          .run  (ena_q.sys),
          .done (lock_done.sys)
        );
      end else begin : g_usb
        lockup_timer #(.STAGES(STAGES_USB)) timer_i (
          .clk  (clk),
          .rst_n(rst_n),
          .run  (ena_q.usb),
          .done (lock_done.usb)
        );
      end
    end
  endgenerate

  assign sys_lock_done = lock_done.sys;
  assign usb_lock_done = lock_done.usb;
  assign busy.sys = ena_q.sys & ~lock_done.sys;
  assign busy.usb = ena_q.usb & ~lock_done.usb;
  assign lock_flag = busy.sys | busy.usb;

  start_guard guard_i (
    .cur_en(ena_q),
    .busy  (busy),
    .req   (req),
    .nxt_en(ena_nxt),
    .reject(start_reject)
  );

  ctrl_regs #(.DATA_W(DATA_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wr_ena      (wr_ena),
    .wdata       (wr_data),
    .ena_nxt     (ena_nxt),
    .start_reject(start_reject),
    .sys_locked  (ena_q.sys & lock_done.sys),
    .ena_q       (ena_q),
    .sel_q       (sel_q),
    .mul_q       (mul_q),
    .err_q       (err_q)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == 1'(REG_CTRL)) begin
      rd_data[CTRL_SEL_BIT]  = sel_q;
      rd_data[CTRL_FLAG_BIT] = lock_flag;
      rd_data[CTRL_MUL_BIT]  = mul_q;
      rd_data[CTRL_ERR_BIT]  = err_q;
    end else begin
      rd_data[ENA_SYS_BIT] = ena_q.sys;
      rd_data[ENA_USB_BIT] = ena_q.usb;
    end
  end

  assign sys_pll_en  = ena_q.sys;
  assign usb_pll_en  = ena_q.usb;
  assign pll_mul16   = mul_q;
  assign clk_sel_pll = sel_q;

endmodule

// File: rtl/pll_lockup_chk.sv
module pll_lockup_chk #(
  parameter int unsigned SB = 12,
  parameter int unsigned UB = 13
) (
  input logic clk,
  input logic rst_n,
  input logic sys_en,
  input logic usb_en,
  input logic sys_done,
  input logic usb_done,
  input logic clk_sel,
  input logic mul16
);

  localparam int unsigned SW = SB + 2;
  localparam int unsigned UW = UB + 2;
  localparam logic [SW-1:0] S_LEN = SW'(1) << SB;
  localparam logic [UW-1:0] U_LEN = UW'(1) << UB;

  logic [SW-1:0] s_age;
  logic [UW-1:0] u_age;

  always_ff @(posedge clk) begin
    if (!rst_n || !sys_en) s_age <= '0;
    else if (s_age != '1)  s_age <= s_age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !usb_en) u_age <= '0;
    else if (u_age != '1)  u_age <= u_age + 1'b1;
  end

  // R2: system lock completes exactly 2^SB edges after the start
  a_r2_sys_lock_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_done) |-> (s_age == S_LEN));

  // R3: USB lock completes exactly 2^UB edges after the start
  a_r3_usb_lock_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_done) |-> (u_age == U_LEN));

  // R5: PLL clock source only while the system loop is enabled and locked
  a_r5_sel_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (sys_en && sys_done));

  // R6: never two loops locking together
  a_r6_single_locking: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_en && !sys_done && usb_en && !usb_done));

  // R8: a disabled loop loses its lock on the next edge
  a_r8_stop_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_en) |=> !sys_done);

  // R9: multiplier frozen while the system loop runs
  a_r9_mul_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_en && $past(sys_en)) |-> $stable(mul16));

endmodule

bind pll_lockup_ctrl pll_lockup_chk #(
  .SB(SYS_LOCK_STAGES),
  .UB(USB_LOCK_STAGES)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .sys_en  (sys_pll_en),
  .usb_en  (usb_pll_en),
  .sys_done(sys_lock_done),
  .usb_done(usb_lock_done),
  .clk_sel (clk_sel_pll),
  .mul16   (pll_mul16)
);

// File: tb/pll_lockup_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_lockup_ctrl_tb_top;

  localparam int SB = 4;
  localparam int UB = 5;
  localparam int N_SYS = 1 << SB;
  localparam int N_USB = 1 << UB;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_addr = 1'b0;
  logic [DW-1:0] rd_data;
  logic          sys_pll_en, usb_pll_en, pll_mul16, clk_sel_pll;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pll_lockup_ctrl #(
    .SYS_LOCK_STAGES(SB),
    .USB_LOCK_STAGES(UB),
    .DATA_W(DW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_pll_en(sys_pll_en), .usb_pll_en(usb_pll_en),
    .pll_mul16(pll_mul16), .clk_sel_pll(clk_sel_pll)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; the next rising edge captures the write
  task automatic wr(input logic a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk_flag(input string req, input int exp);
    logic [DW-1:0] v;
    rd(1'b0, v);
    check(req, int'(v[1]), exp);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [DW-1:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); check("R1 ctrl reg", int'(v), 0);
    rd(1'b1, v); check("R1 enable reg", int'(v), 0);
    check("R1 outputs", int'({sys_pll_en, usb_pll_en, pll_mul16, clk_sel_pll}), 0);

    // R9 multiplier writable while system loop off
    wr(1'b0, 8'h04);
    check("R9 mul set when off", int'(pll_mul16), 1);
    // R5 select refused with loop off
    wr(1'b0, 8'h05);
    check("R5 sel refused while off", int'(clk_sel_pll), 0);

    // start system loop: edge k=0
    wr(1'b1, 8'h01);
    check("R6 sys start accepted", int'(sys_pll_en), 1);
    chk_flag("R4 flag set on start", 1);
    wr(1'b0, 8'h05);                        // k=1
    check("R5 sel refused while locking", int'(clk_sel_pll), 0);
    wr(1'b0, 8'h00);                        // k=2
    check("R9 mul frozen while on", int'(pll_mul16), 1);
    wr(1'b1, 8'h03);                        // k=3
    check("R6 usb start ignored", int'(usb_pll_en), 0);
    rd(1'b0, v); check("R7 err set", int'(v[3]), 1);
    for (int k = 3; k <= N_SYS + 1; k++) begin
      chk_flag("R2 sys lock sweep", (k < N_SYS) ? 1 : 0);
      @(negedge clk);
    end
    wr(1'b0, 8'h08);
    rd(1'b0, v); check("R7 err cleared by write 1", int'(v[3]), 0);
    wr(1'b0, 8'h01);
    check("R5 sel accepted when locked", int'(clk_sel_pll), 1);

    // start USB loop: edge k=0
    wr(1'b1, 8'h03);
    check("R6 usb start after lock", int'(usb_pll_en), 1);
    wr(1'b1, 8'h02);                        // k=1
    check("R8 sys off drops sel", int'(clk_sel_pll), 0);
    check("R8 sys off", int'(sys_pll_en), 0);
    wr(1'b1, 8'h03);                        // k=2
    check("R6 sys start ignored while usb locking", int'(sys_pll_en), 0);
    rd(1'b0, v); check("R7 err set by sys", int'(v[3]), 1);
    for (int k = 2; k <= N_USB + 1; k++) begin
      chk_flag("R3 usb lock sweep", (k < N_USB) ? 1 : 0);
      @(negedge clk);
    end
    wr(1'b0, 8'h08);

    // R8 counter restart: partial lock, stop, restart
    wr(1'b1, 8'h03);
    repeat (5) @(negedge clk);
    chk_flag("R4 flag during partial lock", 1);
    wr(1'b1, 8'h02);
    chk_flag("R4 flag clear when stopped", 0);
    wr(1'b1, 8'h03);                        // k=0
    rd(1'b1, v); check("R10 enable readback", int'(v), 3);
    for (int k = 0; k <= N_SYS + 1; k++) begin
      chk_flag("R8 restart full period", (k < N_SYS) ? 1 : 0);
      @(negedge clk);
    end

    // R6 simultaneous start: system wins
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R10 both off", int'(v), 0);
    wr(1'b1, 8'h03);
    rd(1'b1, v); check("R6 simultaneous start", int'(v), 1);
    rd(1'b0, v); check("R7 err on simultaneous", int'(v[3]), 1);
    wr(1'b0, 8'h08);
    rd(1'b0, v); check("R7 err cleared", int'(v[3]), 0);

    // R9 multiplier back to x12 once off
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    check("R9 mul cleared when off", int'(pll_mul16), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule